// File: doc/BRIEF.md
# Debug Port Mode-Switching Sequence Generator

This block produces the fixed bit sequences a debug probe sends to a two-wire serial debug port to reset its line state or move it between the two-wire protocol, the four-wire boundary-scan protocol and a low-power dormant state. Five sequences are held in the block. A requester picks one with a 3-bit code and a one-cycle start strobe. The block then drives the data line, the line clock and the data output enable until the sequence is complete. At the end it pulses done.

Each sequence bit takes one line clock period, which is two cycles of the system clock. The line clock is low in the first cycle and high in the second. The data line changes only at the falling line-clock edge, so the target samples a settled value on the rising edge. When no sequence runs, the line clock rests low, the data line is low and the enable is off. A code with no stored sequence is refused: the block pulses an error and the line stays untouched.

Top module: `wire_mode_seq_gen`

## Requirements
- R1: While reset is asserted, and once it has been released with no start, busy, done, err, the line clock, the line data and the output enable are all low.
- R2: The number of line clock periods is exact for each code: 0 gives 51, 1 gives 118, 2 gives 71, 3 gives 66 and 4 gives 199.
- R3: Bit i of a sequence is bit (i mod 8) of stored byte i/8, with byte 0 first. Code 0 stores six FF bytes then 03. Code 1 stores six FF, 7B, 9E, six FF, then 0F. Code 2 stores six FF, F3, 9C, FF. Code 3 stores six FF, F3, 8E, 03. Code 4 stores FF; then 92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19; then 10 FA; five FF; then 3F. The output stops after the exact bit count, even in the middle of a byte.
- R4: Each bit period is two system clock cycles with the line clock low and then high. The line data changes only when the line clock falls and is stable while the line clock is high.
- R5: The line clock toggles only while a sequence is active. Otherwise it rests low.
- R6: The output enable is high from the cycle after an accepted start until the last bit period ends, and low at all other times.
- R7: Done is high for exactly one cycle, immediately after the last bit period ends. In that same cycle busy, the enable and the line clock are low.
- R8: A start with a code of 5, 6 or 7 produces a one-cycle err pulse in the following cycle, with no line clock, no enable and busy staying low.
- R9: A start strobe while a sequence is active is ignored. The running sequence completes with its own bits and length.
- R10: The line data is low whenever no sequence is active.
- R11: A start in the cycle where done is high is accepted, so sequences can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request strobe |
| sel_i | input | 3 | Sequence code, sampled with start_i |
| busy_o | output | 1 | A sequence is being emitted |
| done_o | output | 1 | One-cycle pulse when a sequence has finished |
| err_o | output | 1 | One-cycle pulse for an unsupported code |
| line_clk_o | output | 1 | Debug line clock |
| line_data_o | output | 1 | Debug data line value |
| line_oe_o | output | 1 | Data line output enable |

## Verification
The embedded assertions check several relations on every cycle. The line clock is low whenever the block is idle. The data line holds still through each high phase of the line clock. Done lasts one cycle and coincides with the end of activity. An error leaves the line idle. A running selection cannot change, and the bit index never passes the end of the selected sequence. The exact bit content and the per-code lengths can only be shown by the bench's scenarios. The same holds for the placement of the enable window, for refused starts during a run, and for back-to-back starts. The bench compares every emitted bit against a byte table it holds itself and counts rising line-clock edges per run.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int SEL_W   = 3;
  localparam int NUM_SEQ = 5;
  localparam int MAX_LEN = 200;
  localparam int IDX_W   = $clog2(MAX_LEN);

  localparam logic [SEL_W-1:0] CODE_LINE_RST  = 3'd0;
  localparam logic [SEL_W-1:0] CODE_TO_2WIRE  = 3'd1;
  localparam logic [SEL_W-1:0] CODE_TO_4WIRE  = 3'd2;
  localparam logic [SEL_W-1:0] CODE_TO_DORM   = 3'd3;
  localparam logic [SEL_W-1:0] CODE_WAKE      = 3'd4;

  // Patterns are packed so that vector bit i is the i-th bit on the line.
  function automatic logic [MAX_LEN-1:0] pat_vec(input int s);
    case (s)
      0:       pat_vec = MAX_LEN'(56'h03_FFFF_FFFF_FFFF);
      1:       pat_vec = MAX_LEN'(120'h0F_FFFF_FFFF_FFFF_9E7B_FFFF_FFFF_FFFF);
      2:       pat_vec = MAX_LEN'(72'hFF_9CF3_FFFF_FFFF_FFFF);
      3:       pat_vec = MAX_LEN'(72'h03_8EF3_FFFF_FFFF_FFFF);
      4:       pat_vec = 200'h3FFF_FFFF_FFFF_FA10_19BC_0EA2_E3DD_AFE9_8685_2D95_6209_F392_FF;
      default: pat_vec = '0;
    endcase
  endfunction

  // Index of the final bit of each sequence (length minus one).
  function automatic logic [IDX_W-1:0] last_idx(input int s);
    case (s)
      0:       last_idx = IDX_W'(50);
      1:       last_idx = IDX_W'(117);
      2:       last_idx = IDX_W'(70);
      3:       last_idx = IDX_W'(65);
      4:       last_idx = IDX_W'(198);
      default: last_idx = '0;
    endcase
  endfunction
endpackage

// File: rtl/wseq_rst_sync.sv
module wseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wseq_pattern_rom.sv
module wseq_pattern_rom
  import wseq_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o,
  output logic [IDX_W-1:0] last_o
);
  logic [NUM_SEQ-1:0]   bit_per_seq;
  logic [IDX_W-1:0]     last_per_seq [NUM_SEQ];

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    localparam logic [MAX_LEN-1:0] PAT  = pat_vec(s);
    localparam logic [IDX_W-1:0]   LAST = last_idx(s);
    always_comb begin
      bit_per_seq[s]  = PAT[idx_i];
      last_per_seq[s] = LAST;
    end
  end

  always_comb begin
    bit_o  = 1'b0;
    last_o = '0;
    for (int s = 0; s < NUM_SEQ; s++) begin
      if (sel_i == SEL_W'(s)) begin
        bit_o  = bit_per_seq[s];
        last_o = last_per_seq[s];
      end
    end
  end
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rom_bit_i,
  input  logic [IDX_W-1:0] rom_last_i,
  output logic [SEL_W-1:0] rom_sel_o,
  output logic [IDX_W-1:0] rom_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             line_clk_o,
  output logic             line_data_o,
  output logic             line_oe_o
);
  logic             busy_q, busy_n;
  logic             phase_q, phase_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic             data_q, data_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic             sel_ok;
  logic             at_last;

  assign sel_ok    = (sel_i < SEL_W'(NUM_SEQ));
  assign rom_sel_o = busy_q ? sel_q : sel_i;
  assign rom_idx_o = busy_q ? idx_q + 1'b1 : '0;
  assign at_last   = (idx_q == rom_last_i);

  always_comb begin
    busy_n  = busy_q;
    phase_n = phase_q;
    idx_n   = idx_q;
    sel_n   = sel_q;
    data_n  = data_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        if (sel_ok) begin
          busy_n  = 1'b1;
          sel_n   = sel_i;
          idx_n   = '0;
          phase_n = 1'b0;
          data_n  = rom_bit_i;
        end else begin
          err_n = 1'b1;
        end
      end
    end else if (!phase_q) begin
      phase_n = 1'b1;
    end else begin
      phase_n = 1'b0;
      if (at_last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        data_n = 1'b0;
      end else begin
        idx_n  = idx_q + 1'b1;
        data_n = rom_bit_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      idx_q   <= '0;
      sel_q   <= '0;
      data_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      phase_q <= phase_n;
      idx_q   <= idx_n;
      sel_q   <= sel_n;
      data_q  <= data_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign line_clk_o  = phase_q;
  assign line_data_o = data_q;
  assign line_oe_o   = busy_q;

  // R5: line clock rests low when idle
  assert_clk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !phase_q);
  // R4: data held across the high half of the line clock
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> $stable(data_q));
  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: activity ends together with done
  assert_end_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R8: refused code leaves the line idle
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && !phase_q));
  // R9: selection frozen while running
  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q));
  // R2: index never passes the selected sequence end
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= rom_last_i));
  // R10: data low when idle
  assert_data_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !data_q);
endmodule

// File: rtl/wire_mode_seq_gen.sv
module wire_mode_seq_gen
  import wseq_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             line_clk_o,
  output logic             line_data_o,
  output logic             line_oe_o
);
  logic             rst_n;
  logic [SEL_W-1:0] rom_sel;
  logic [IDX_W-1:0] rom_idx;
  logic             rom_bit;
  logic [IDX_W-1:0] rom_last;

  wseq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  wseq_pattern_rom u_rom (
    .sel_i  (rom_sel),
    .idx_i  (rom_idx),
    .bit_o  (rom_bit),
    .last_o (rom_last)
  );

  wseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sel_i       (sel_i),
    .rom_bit_i   (rom_bit),
    .rom_last_i  (rom_last),
    .rom_sel_o   (rom_sel),
    .rom_idx_o   (rom_idx),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .line_clk_o  (line_clk_o),
    .line_data_o (line_data_o),
    .line_oe_o   (line_oe_o)
  );
endmodule

// File: tb/tb_wire_mode_seq_gen.sv
`timescale 1ns/1ps
module tb_wire_mode_seq_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       start_i;
  logic [2:0] sel_i;
  logic busy_o, done_o, err_o, line_clk_o, line_data_o, line_oe_o;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge line_clk_o) edges <= edges + 1;

  wire_mode_seq_gen dut (
    .clk(clk), .arst_n(arst_n), .start_i(start_i), .sel_i(sel_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .line_clk_o(line_clk_o), .line_data_o(line_data_o), .line_oe_o(line_oe_o)
  );

  function automatic int seq_len(input int s);
    case (s)
      0: return 51;
      1: return 118;
      2: return 71;
      3: return 66;
      default: return 199;
    endcase
  endfunction

  function automatic logic [7:0] alert_byte(input int k);
    case (k)
      0: return 8'h92;  1: return 8'hF3;  2: return 8'h09;  3: return 8'h62;
      4: return 8'h95;  5: return 8'h2D;  6: return 8'h85;  7: return 8'h86;
      8: return 8'hE9;  9: return 8'hAF; 10: return 8'hDD; 11: return 8'hE3;
      12: return 8'hA2; 13: return 8'h0E; 14: return 8'hBC; default: return 8'h19;
    endcase
  endfunction

  function automatic logic [7:0] seq_byte(input int s, input int k);
    case (s)
      0: return (k < 6) ? 8'hFF : 8'h03;
      1: begin
        if (k == 6) return 8'h7B;
        if (k == 7) return 8'h9E;
        if (k == 14) return 8'h0F;
        return 8'hFF;
      end
      2: begin
        if (k == 6) return 8'hF3;
        if (k == 7) return 8'h9C;
        return 8'hFF;
      end
      3: begin
        if (k == 6) return 8'hF3;
        if (k == 7) return 8'h8E;
        if (k == 8) return 8'h03;
        return 8'hFF;
      end
      default: begin
        if (k >= 1 && k <= 16) return alert_byte(k - 1);
        if (k == 17) return 8'h10;
        if (k == 18) return 8'hFA;
        if (k == 24) return 8'h3F;
        return 8'hFF;
      end
    endcase
  endfunction

  function automatic logic exp_bit(input int s, input int i);
    logic [7:0] b;
    b = seq_byte(s, i / 8);
    return b[i % 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a start at the current falling edge; returns one falling edge later.
  task automatic launch(input int s);
    sel_i   = 3'(s);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Observe a full accepted sequence; ends at the falling edge of the done cycle.
  task automatic observe(input int s, input bit intrude);
    int n, e0;
    n  = seq_len(s);
    e0 = edges;
    for (int k = 0; k < n; k++) begin
      if (intrude && k == 3) begin
        sel_i   = 3'((s + 2) % 5);
        start_i = 1'b1;
      end
      chk(line_oe_o == 1'b1 && busy_o == 1'b1, "R6 enable during sequence", int'(line_oe_o), 1);
      chk(line_clk_o == 1'b0, "R4 low half of bit period", int'(line_clk_o), 0);
      chk(line_data_o == exp_bit(s, k), (intrude ? "R9 bit after ignored start" : "R3 bit value"),
          int'(line_data_o), int'(exp_bit(s, k)));
      @(negedge clk);
      start_i = 1'b0;
      chk(line_clk_o == 1'b1, "R4 high half of bit period", int'(line_clk_o), 1);
      chk(line_data_o == exp_bit(s, k), "R4 data stable while clock high",
          int'(line_data_o), int'(exp_bit(s, k)));
      @(negedge clk);
    end
    chk(done_o == 1'b1, "R7 done after last period", int'(done_o), 1);
    chk(busy_o == 1'b0 && line_oe_o == 1'b0 && line_clk_o == 1'b0,
        "R7 idle with done", int'({busy_o, line_oe_o, line_clk_o}), 0);
    chk(line_data_o == 1'b0, "R10 data low after sequence", int'(line_data_o), 0);
    chk(edges - e0 == n, "R2 line clock period count", edges - e0, n);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
    chk(line_clk_o == 1'b0 && line_oe_o == 1'b0, "R5 line clock idle low",
        int'({line_clk_o, line_oe_o}), 0);
    chk(line_data_o == 1'b0, "R10 data low when idle", int'(line_data_o), 0);
  endtask

  task automatic bad_code(input int s);
    int e0;
    e0 = edges;
    launch(s);
    chk(err_o == 1'b1, "R8 err pulse", int'(err_o), 1);
    chk(busy_o == 1'b0 && line_oe_o == 1'b0 && line_clk_o == 1'b0,
        "R8 no line activity", int'({busy_o, line_oe_o, line_clk_o}), 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R8 err one cycle", int'(err_o), 0);
    chk(edges == e0 && line_oe_o == 1'b0, "R8 no clock edges", edges - e0, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    arst_n  = 1'b0;
    start_i = 1'b0;
    sel_i   = '0;
    repeat (3) @(negedge clk);
    chk(line_clk_o == 1'b0 && line_oe_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0 &&
        err_o == 1'b0 && line_data_o == 1'b0, "R1 outputs in reset",
        int'({line_clk_o, line_oe_o, busy_o, done_o, err_o, line_data_o}), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(line_clk_o == 1'b0 && line_oe_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0 &&
        err_o == 1'b0 && line_data_o == 1'b0, "R1 outputs after reset release",
        int'({line_clk_o, line_oe_o, busy_o, done_o, err_o, line_data_o}), 0);

    // Directed: every code once
    for (int s = 0; s < 5; s++) begin
      launch(s);
      observe(s, 1'b0);
      idle_chk();
    end
    // Directed: refused codes
    bad_code(5);
    bad_code(7);
    // Directed: start while busy (R9)
    launch(0);
    observe(0, 1'b1);
    idle_chk();
    // Directed: back to back (R11)
    launch(3);
    observe(3, 1'b0);
    launch(1);
    chk(busy_o == 1'b1, "R11 start in done cycle accepted", int'(busy_o), 1);
    observe(1, 1'b0);
    idle_chk();

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int s;
      bit intr, b2b;
      s    = $urandom_range(0, 7);
      intr = ($urandom_range(0, 3) == 0);
      b2b  = ($urandom_range(0, 2) == 0);
      if (s >= 5) begin
        bad_code(s);
      end else begin
        launch(s);
        observe(s, intr);
        if (b2b) begin
          int s2;
          s2 = $urandom_range(0, 4);
          launch(s2);
          chk(busy_o == 1'b1, "R11 back-to-back accepted", int'(busy_o), 1);
          observe(s2, 1'b0);
        end
        idle_chk();
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule